// File: doc/BRIEF.md
# NAND Flash Byte-Bus Bridge

This block sits between a simple single-master processor bus and one 8-bit raw NAND flash device. Software reaches the flash through a memory window. Each byte access into that window becomes one strobed cycle on the NAND pins. The kind of NAND cycle is carried in low address bits of the access itself. Bit 2 raises the address latch, bit 3 raises the command latch, and bit 4 asserts chip select for that single cycle. So a command byte, an address byte and a data byte differ only in which offset inside the window software writes to.

A small register space sits on a separate select. It holds the window placement, a control word and a status word. The control word turns NAND mode and the chip-enable gate on or off, and it steers writes and reads to one of two chip-select pins. The status word shows the synchronised ready/busy pin of the device and a sticky flag. That flag rises when a write cycle has fully left the NAND bus. The flag is cleared again when the next write cycle starts.

The processor bus stalls (ready low) for the whole of a NAND cycle, so only one cycle is ever in flight. The strobe, hold and recovery lengths are parameters counted in units of a base-clock multiplier. The defaults give an 8-clock strobe, a 4-clock hold and a 4-clock recovery.

Top module: `nand_bus_bridge`

## Requirements
- R1: A window access is forwarded only when the window is enabled (bit 0 of the window register at offset 0x24). The address bits from bit 8 upward must also equal the base field in bits 15:8. Mask field bits 7:4 each exempt one address bit 8..11 from that compare. Any other window access completes with ready in the same cycle, reads as zero and produces no NAND strobe.
- R2: For a forwarded access, address bit 2 drives ALE, bit 3 drives CLE and bit 4 allows chip select, for that cycle only. A command byte such as 0xFF at offset 0x18 appears with CLE high and ALE low.
- R3: A write holds WE# low for WR_WAIT×MULT clocks (8) with the byte driven. Data stays driven for a further HOLD×MULT clocks (4) after WE# rises. Chip select is active for exactly those 12 clocks, and RECOV×MULT clocks (4) of recovery follow.
- R4: A read holds RE# low for RD_WAIT×MULT clocks (8). It samples the NAND data on the last low clock and returns that byte in bits 7:0 of the bus read data. WE# and RE# are never low together.
- R5: A register access completes in its first cycle. A forwarded NAND access raises ready after 1 + (WAIT+HOLD+RECOV)×MULT clocks (17).
- R6: Bit 3 of the status register at offset 0xB4 reads 0 after reset. It reads 1 once a write cycle's recovery has ended. It is cleared when a new write cycle starts, and read cycles and register accesses leave it unchanged.
- R7: Bit 0 of the status register shows the ready/busy pin after a two-flop synchroniser. A change is seen by a register read made after the second clock edge, but not after only the first.
- R8: Control register offset 0xB0, bit 0 enables NAND mode and bit 20 gates chip enable. With mode off, window accesses are ignored as in R1. With mode on and the gate off, strobes run but no chip-select pin asserts.
- R9: Control bit 10 routes write cycles to chip-select pin 1 and bit 8 routes read cycles to pin 1; when clear, pin 0 is used. At most one chip-select pin is active.
- R10: Control bits 0, 1, 8, 10 and 20 read back as written. The window register reads back base, mask and enable, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reg_sel | input | 1 | Register-space access request |
| bus_mem_sel | input | 1 | Memory-window access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (16) | Byte address; low 8 bits are the register offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes at the next clock edge |
| nand_ce_n | output | 2 | Active-low chip selects |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Data to the device |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_i | input | 8 | Data from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The assertions take for granted that the master holds select, direction, address and write data steady from request until it sees ready, and drops select right after that edge. They also assume only one of the two selects is high at a time. The bench drives every access through a single task. That task raises the request just after a falling edge and releases it just after the completing rising edge, so the protocol is followed. The NAND responder only drives read data and never loads the strobes, so every pin timing seen is the bridge's own.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_STROBE,
      PH_HOLD,
      PH_RECOV,
      PH_DONE
   } nb_phase_e;

   typedef struct packed {
      logic cs;
      logic cle;
      logic ale;
   } nb_latch_t;

   // control word bit positions
   localparam int unsigned CB_MODE = 0;
   localparam int unsigned CB_MUX  = 1;
   localparam int unsigned CB_IN1  = 8;
   localparam int unsigned CB_OUT1 = 10;
   localparam int unsigned CB_CE   = 20;

   // status word bit positions
   localparam int unsigned SB_RB = 0;
   localparam int unsigned SB_WC = 3;

   // window register mask field position
   localparam int unsigned WB_MASK_LSB = 4;

   // address bits carrying the cycle type
   localparam int unsigned AB_ALE = 2;
   localparam int unsigned AB_CLE = 3;
   localparam int unsigned AB_CS  = 4;

endpackage

// File: rtl/nbr_sync.sv
module nbr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nbr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/nbr_regs.sv
module nbr_regs
   import nand_bridge_pkg::*;
#(
   parameter int unsigned AW      = 16,
   parameter int unsigned DW      = 32,
   parameter int unsigned WIN_LSB = 8,
   parameter int unsigned MASK_W  = 4,
   parameter logic [7:0]  OFS_WIN  = 8'h24,
   parameter logic [7:0]  OFS_CTRL = 8'hB0,
   parameter logic [7:0]  OFS_STAT = 8'hB4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_sel,
   input  logic          reg_wr,
   input  logic [7:0]    reg_ofs,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic [AW-1:0] mem_addr,
   input  logic          stat_wc,
   input  logic          stat_rb,
   output logic          win_hit,
   output logic          ctrl_mode,
   output logic          ctrl_ce,
   output logic          ctrl_in1,
   output logic          ctrl_out1
);

   localparam int unsigned BASE_W = AW - WIN_LSB;

   generate
      if (DW < CB_CE + 1) begin : g_bad_dw
         $error("nbr_regs: DW too narrow for the control word");
      end
      if (WIN_LSB < WB_MASK_LSB + MASK_W) begin : g_bad_lsb
         $error("nbr_regs: WIN_LSB overlaps the mask field");
      end
      if (BASE_W < MASK_W) begin : g_bad_aw
         $error("nbr_regs: AW leaves too few base bits for the mask");
      end
      if (DW < AW) begin : g_bad_width
         $error("nbr_regs: DW must cover AW");
      end
   endgenerate

   logic [BASE_W-1:0] win_base;
   logic [MASK_W-1:0] win_mask;
   logic              win_en;
   logic              ctrl_mux;

   logic wr_win, wr_ctrl;
   assign wr_win  = reg_sel && reg_wr && (reg_ofs == OFS_WIN);
   assign wr_ctrl = reg_sel && reg_wr && (reg_ofs == OFS_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_base  <= '0;
         win_mask  <= '0;
         win_en    <= 1'b0;
         ctrl_mode <= 1'b0;
         ctrl_mux  <= 1'b0;
         ctrl_in1  <= 1'b0;
         ctrl_out1 <= 1'b0;
         ctrl_ce   <= 1'b0;
      end else begin
         if (wr_win) begin
            win_base <= reg_wdata[AW-1:WIN_LSB];
            win_mask <= reg_wdata[WB_MASK_LSB +: MASK_W];
            win_en   <= reg_wdata[0];
         end
         if (wr_ctrl) begin
            ctrl_mode <= reg_wdata[CB_MODE];
            ctrl_mux  <= reg_wdata[CB_MUX];
            ctrl_in1  <= reg_wdata[CB_IN1];
            ctrl_out1 <= reg_wdata[CB_OUT1];
            ctrl_ce   <= reg_wdata[CB_CE];
         end
      end
   end

   // window compare with don't-care bits
   logic [BASE_W-1:0] ignore_bits;
   logic [BASE_W-1:0] diff_bits;
   assign ignore_bits = {{(BASE_W-MASK_W){1'b0}}, win_mask};
   assign diff_bits   = (mem_addr[AW-1:WIN_LSB] ^ win_base) & ~ignore_bits;
   assign win_hit     = win_en && (diff_bits == '0);

   always_comb begin
      reg_rdata = '0;
      case (reg_ofs)
         OFS_WIN: begin
            reg_rdata[AW-1:WIN_LSB]          = win_base;
            reg_rdata[WB_MASK_LSB +: MASK_W] = win_mask;
            reg_rdata[0]                     = win_en;
         end
         OFS_CTRL: begin
            reg_rdata[CB_MODE] = ctrl_mode;
            reg_rdata[CB_MUX]  = ctrl_mux;
            reg_rdata[CB_IN1]  = ctrl_in1;
            reg_rdata[CB_OUT1] = ctrl_out1;
            reg_rdata[CB_CE]   = ctrl_ce;
         end
         OFS_STAT: begin
            reg_rdata[SB_RB] = stat_rb;
            reg_rdata[SB_WC] = stat_wc;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R10: a control write is reflected on the next cycle
   p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_mode == $past(reg_wdata[CB_MODE])) && (ctrl_ce == $past(reg_wdata[CB_CE])));

endmodule

// File: rtl/nbr_cycle.sv
module nbr_cycle
   import nand_bridge_pkg::*;
#(
   parameter int unsigned NW      = 8,
   parameter int unsigned MULT    = 4,
   parameter int unsigned WR_WAIT = 2,
   parameter int unsigned RD_WAIT = 2,
   parameter int unsigned HOLD    = 1,
   parameter int unsigned RECOV   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_wr,
   input  nb_latch_t     start_lat,
   input  logic [NW-1:0] start_byte,
   input  logic [NW-1:0] dq_i,
   output nb_phase_e     phase,
   output logic          cyc_wr,
   output logic          lat_cs,
   output logic          lat_cle,
   output logic          lat_ale,
   output logic          we_n,
   output logic          re_n,
   output logic [NW-1:0] dq_o,
   output logic          dq_oe,
   output logic [NW-1:0] rd_byte,
   output logic          wc_flag,
   output logic          done
);

   generate
      if (MULT < 1 || WR_WAIT < 1 || RD_WAIT < 1 || HOLD < 1 || RECOV < 1) begin : g_bad_timing
         $error("nbr_cycle: every timing parameter must be at least 1");
      end
   endgenerate

   localparam int unsigned L_WR  = WR_WAIT * MULT;
   localparam int unsigned L_RD  = RD_WAIT * MULT;
   localparam int unsigned L_HLD = HOLD * MULT;
   localparam int unsigned L_REC = RECOV * MULT;
   localparam int unsigned L_M1  = (L_WR > L_RD) ? L_WR : L_RD;
   localparam int unsigned L_M2  = (L_HLD > L_REC) ? L_HLD : L_REC;
   localparam int unsigned L_MAX = (L_M1 > L_M2) ? L_M1 : L_M2;
   localparam int unsigned CW    = $clog2(L_MAX + 1);

   logic [CW-1:0] cnt;
   nb_latch_t     cyc_lat;
   logic          cnt_zero;
   logic          active;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         cyc_wr  <= 1'b0;
         cyc_lat <= '0;
         dq_o    <= '0;
         rd_byte <= '0;
         wc_flag <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase   <= PH_STROBE;
                  cyc_wr  <= start_wr;
                  cyc_lat <= start_lat;
                  if (start_wr) begin
                     dq_o    <= start_byte;
                     wc_flag <= 1'b0;
                     cnt     <= CW'(L_WR - 1);
                  end else begin
                     cnt     <= CW'(L_RD - 1);
                  end
               end
            end
            PH_STROBE: begin
               if (cnt_zero) begin
                  if (!cyc_wr) rd_byte <= dq_i;
                  phase <= PH_HOLD;
                  cnt   <= CW'(L_HLD - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_zero) begin
                  phase <= PH_RECOV;
                  cnt   <= CW'(L_REC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_RECOV: begin
               if (cnt_zero) begin
                  phase <= PH_DONE;
                  if (cyc_wr) wc_flag <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign active  = (phase == PH_STROBE) || (phase == PH_HOLD);
   assign lat_cs  = active && cyc_lat.cs;
   assign lat_cle = active && cyc_lat.cle;
   assign lat_ale = active && cyc_lat.ale;
   assign we_n    = !((phase == PH_STROBE) && cyc_wr);
   assign re_n    = !((phase == PH_STROBE) && !cyc_wr);
   assign dq_oe   = active && cyc_wr;
   assign done    = (phase == PH_DONE);

   // R3: driven write data never changes while it is on the bus
   p_dq_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

   // R4: the two strobes are never low together
   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we_n || re_n);

   // R6: starting a write clears the completion flag
   p_wc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) && start && start_wr) |=> !wc_flag);

   // R6: the flag moves only at a write start or at the end of recovery
   p_wc_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!((phase == PH_IDLE) && start && start_wr) && (phase != PH_RECOV)) |=> $stable(wc_flag));

endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
   import nand_bridge_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 32,
   parameter int unsigned NW          = 8,
   parameter int unsigned WIN_LSB     = 8,
   parameter int unsigned MASK_W      = 4,
   parameter int unsigned MULT        = 4,
   parameter int unsigned WR_WAIT     = 2,
   parameter int unsigned RD_WAIT     = 2,
   parameter int unsigned HOLD        = 1,
   parameter int unsigned RECOV       = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_reg_sel,
   input  logic          bus_mem_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          bus_ready,
   output logic [1:0]    nand_ce_n,
   output logic          nand_cle,
   output logic          nand_ale,
   output logic          nand_we_n,
   output logic          nand_re_n,
   output logic [NW-1:0] nand_dq_o,
   output logic          nand_dq_oe,
   input  logic [NW-1:0] nand_dq_i,
   input  logic          nand_rb_n
);

   localparam int unsigned NUM_CE = 2;

   generate
      if (AW <= AB_CS) begin : g_bad_aw
         $error("nand_bus_bridge: AW must include the cycle-type bits");
      end
      if (DW < NW) begin : g_bad_dw
         $error("nand_bus_bridge: DW narrower than the NAND bus");
      end
   endgenerate

   logic      win_hit, ctrl_mode, ctrl_ce, ctrl_in1, ctrl_out1;
   logic      rb_sync;
   logic      wc_flag, done, cyc_wr, lat_cs;
   logic      start;
   nb_phase_e phase;
   nb_latch_t start_lat;
   logic [DW-1:0] reg_rdata;
   logic [NW-1:0] rd_byte;

   nbr_regs #(
      .AW(AW), .DW(DW), .WIN_LSB(WIN_LSB), .MASK_W(MASK_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (bus_reg_sel),
      .reg_wr    (bus_wr),
      .reg_ofs   (bus_addr[7:0]),
      .reg_wdata (bus_wdata),
      .reg_rdata (reg_rdata),
      .mem_addr  (bus_addr),
      .stat_wc   (wc_flag),
      .stat_rb   (rb_sync),
      .win_hit   (win_hit),
      .ctrl_mode (ctrl_mode),
      .ctrl_ce   (ctrl_ce),
      .ctrl_in1  (ctrl_in1),
      .ctrl_out1 (ctrl_out1)
   );

   nbr_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (nand_rb_n),
      .q_sync  (rb_sync)
   );

   assign start_lat.cs  = bus_addr[AB_CS];
   assign start_lat.cle = bus_addr[AB_CLE];
   assign start_lat.ale = bus_addr[AB_ALE];
   assign start = bus_mem_sel && win_hit && ctrl_mode && (phase == PH_IDLE);

   nbr_cycle #(
      .NW(NW), .MULT(MULT), .WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT),
      .HOLD(HOLD), .RECOV(RECOV)
   ) u_cycle (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_wr   (bus_wr),
      .start_lat  (start_lat),
      .start_byte (bus_wdata[NW-1:0]),
      .dq_i       (nand_dq_i),
      .phase      (phase),
      .cyc_wr     (cyc_wr),
      .lat_cs     (lat_cs),
      .lat_cle    (nand_cle),
      .lat_ale    (nand_ale),
      .we_n       (nand_we_n),
      .re_n       (nand_re_n),
      .dq_o       (nand_dq_o),
      .dq_oe      (nand_dq_oe),
      .rd_byte    (rd_byte),
      .wc_flag    (wc_flag),
      .done       (done)
   );

   // chip-select routing: writes and reads each pick their own pin
   logic ce_route;
   logic ce_gate;
   assign ce_route = cyc_wr ? ctrl_out1 : ctrl_in1;
   assign ce_gate  = lat_cs && ctrl_mode && ctrl_ce;

   generate
      for (genvar c = 0; c < NUM_CE; c++) begin : g_ce
         assign nand_ce_n[c] = !(ce_gate && (ce_route == c[0]));
      end
   endgenerate

   logic ignored;
   assign ignored   = bus_mem_sel && (phase == PH_IDLE) && !(win_hit && ctrl_mode);
   assign bus_ready = bus_reg_sel || ignored || done;

   always_comb begin
      bus_rdata = '0;
      if (bus_reg_sel)
         bus_rdata = reg_rdata;
      else if (done && !cyc_wr)
         bus_rdata[NW-1:0] = rd_byte;
   end

   // R8: a chip-select pin is active only with mode and gate both on
   p_ce_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_ce_n != 2'b11) |-> (ctrl_mode && ctrl_ce));

   // R9: never both chip-select pins at once
   p_one_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n));

   // R1: an access outside the window starts no NAND cycle
   p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) && bus_mem_sel && !win_hit) |=> (phase == PH_IDLE));

   // R5: a finished cycle returns to idle straight away
   p_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (phase == PH_IDLE));

endmodule

// File: tb/nand_bus_bridge_bench.sv
`timescale 1ns/1ps
module nand_bus_bridge_bench;

   localparam int MULT = 4, WRW = 2, RDW = 2, HLD = 1, REC = 1;
   localparam int EXP_WE  = WRW * MULT;
   localparam int EXP_RE  = RDW * MULT;
   localparam int EXP_OE  = (WRW + HLD) * MULT;
   localparam int EXP_LAT = 1 + (WRW + HLD + REC) * MULT;
   localparam logic [15:0] A_WIN = 16'h0024, A_CTRL = 16'h00B0, A_STAT = 16'h00B4;

   logic clk = 0, rst_n = 0;
   logic bus_reg_sel = 0, bus_mem_sel = 0, bus_wr = 0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic bus_ready;
   logic [1:0] nand_ce_n;
   logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0] nand_dq_o, nand_dq_i = 8'h00;
   logic nand_rb_n = 0;

   always #10 clk = ~clk;

   nand_bus_bridge u_nand_bus_bridge (
      .clk(clk), .rst_n(rst_n), .bus_reg_sel(bus_reg_sel), .bus_mem_sel(bus_mem_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
   );

   int checks = 0, failures = 0;
   bit finished = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // pin monitor, sampled on the falling edge
   int we_run = 0, we_last = 0, re_run = 0, re_last = 0, oe_run = 0, oe_last = 0;
   int ce_run = 0, ce_last = 0, we_count = 0, re_count = 0, ce_count = 0;
   logic cap_cle, cap_ale;
   logic [1:0] cap_ce_n, cap_rce_n;
   logic [7:0] cap_dq;
   logic prev_we = 1, prev_re = 1;

   always @(negedge clk) begin
      if (!nand_we_n) begin
         we_run++;
         cap_cle = nand_cle; cap_ale = nand_ale; cap_ce_n = nand_ce_n; cap_dq = nand_dq_o;
      end else if (we_run > 0) begin we_last = we_run; we_run = 0; end
      if (!nand_re_n) begin re_run++; cap_rce_n = nand_ce_n; end
      else if (re_run > 0) begin re_last = re_run; re_run = 0; end
      if (nand_dq_oe) oe_run++;
      else if (oe_run > 0) begin oe_last = oe_run; oe_run = 0; end
      if (nand_ce_n != 2'b11) begin ce_run++; ce_count++; end
      else if (ce_run > 0) begin ce_last = ce_run; ce_run = 0; end
      if (prev_we && !nand_we_n) we_count++;
      if (prev_re && !nand_re_n) re_count++;
      prev_we = nand_we_n; prev_re = nand_re_n;
   end

   task automatic xfer(input logic is_reg, input logic wr, input logic [15:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
      @(negedge clk);
      bus_reg_sel = is_reg; bus_mem_sel = !is_reg; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      lat = 0;
      #1;
      while (!bus_ready && lat < 1000) begin @(negedge clk); #1; lat++; end
      rd = bus_rdata;
      @(posedge clk); #1;
      bus_reg_sel = 0; bus_mem_sel = 0; bus_wr = 0;
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int lat, wc0, rc0, cc0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R3 reset ce_n", nand_ce_n, 2'b11);
      chk("R3 reset we_n/re_n/oe", {nand_we_n, nand_re_n, nand_dq_oe}, 3'b110);
      xfer(1, 0, A_CTRL, 0, rd, lat); chk("R10 reset ctrl", rd, 0);
      chk("R5 register latency", lat, 0);
      xfer(1, 0, A_STAT, 0, rd, lat); chk("R6 reset status", rd, 0);

      // R1: disabled window is ignored
      wc0 = we_count;
      xfer(0, 1, 16'h4010, 32'h55, rd, lat);
      chk("R1 disabled window latency", lat, 0);
      repeat (20) @(negedge clk);
      chk("R1 disabled window strobes", we_count, wc0);

      xfer(1, 1, A_WIN, 32'h0000_4001, rd, lat);
      xfer(1, 1, A_CTRL, 32'hFFFF_FFFF, rd, lat);
      xfer(1, 0, A_CTRL, 0, rd, lat); chk("R10 ctrl readback", rd, 32'h0010_0503);
      xfer(1, 0, A_WIN, 0, rd, lat); chk("R10 window readback", rd, 32'h0000_4001);
      xfer(1, 1, A_CTRL, 32'h0010_0001, rd, lat);

      // R2: reset command byte at CLE|CS offset
      xfer(0, 1, 16'h4018, 32'hFF, rd, lat);
      chk("R2 reset cmd cle/ale", {cap_cle, cap_ale}, 2'b10);
      chk("R2 reset cmd byte", cap_dq, 8'hFF);
      chk("R5 write latency", lat, EXP_LAT);
      xfer(1, 0, A_STAT, 0, rd, lat); chk("R6 wc after write", rd[3], 1);

      // R2/R3: sweep all cycle-type combinations
      for (int k = 0; k < 8; k++) begin
         cc0 = ce_count;
         xfer(0, 1, 16'h4000 | 16'(k << 2), 32'h30 + k, rd, lat);
         repeat (2) @(negedge clk);
         chk("R2 ale", cap_ale, k[0]);
         chk("R2 cle", cap_cle, k[1]);
         chk("R2 cs", cap_ce_n, k[2] ? 2'b10 : 2'b11);
         chk("R3 data byte", cap_dq, 8'h30 + k);
         chk("R3 we low clocks", we_last, EXP_WE);
         chk("R3 data driven clocks", oe_last, EXP_OE);
         if (k[2]) chk("R3 ce active clocks", ce_last, EXP_OE);
         else      chk("R2 no ce without bit4", ce_count, cc0);
         chk("R5 latency", lat, EXP_LAT);
      end

      // R4: reads
      for (int k = 0; k < 4; k++) begin
         logic [7:0] pat;
         pat = 8'(k * 8'h5A + 8'h0F);
         nand_dq_i = pat;
         wc0 = we_count;
         xfer(0, 0, 16'h4010, 0, rd, lat);
         repeat (2) @(negedge clk);
         chk("R4 read data", rd, {24'h0, pat});
         chk("R4 re low clocks", re_last, EXP_RE);
         chk("R4 read ce pin 0", cap_rce_n, 2'b10);
         chk("R4 no write strobe", we_count, wc0);
         chk("R5 read latency", lat, EXP_LAT);
      end
      xfer(1, 0, A_STAT, 0, rd, lat); chk("R6 wc kept by reads", rd[3], 1);

      // R8: gate off, then mode off
      xfer(1, 1, A_CTRL, 32'h0000_0001, rd, lat);
      cc0 = ce_count; wc0 = we_count;
      xfer(0, 1, 16'h4010, 32'h11, rd, lat);
      repeat (2) @(negedge clk);
      chk("R8 strobe with gate off", we_count, wc0 + 1);
      chk("R8 no ce with gate off", ce_count, cc0);
      xfer(1, 1, A_CTRL, 32'h0010_0000, rd, lat);
      wc0 = we_count;
      xfer(0, 1, 16'h4010, 32'h22, rd, lat);
      chk("R8 mode off latency", lat, 0);
      repeat (20) @(negedge clk);
      chk("R8 mode off no strobe", we_count, wc0);

      // R9: chip-select routing
      xfer(1, 1, A_CTRL, 32'h0010_0401, rd, lat);
      xfer(0, 1, 16'h4010, 32'h33, rd, lat);
      chk("R9 write on pin 1", cap_ce_n, 2'b01);
      xfer(0, 0, 16'h4010, 0, rd, lat);
      chk("R9 read on pin 0", cap_rce_n, 2'b10);
      xfer(1, 1, A_CTRL, 32'h0010_0101, rd, lat);
      xfer(0, 0, 16'h4010, 0, rd, lat);
      chk("R9 read on pin 1", cap_rce_n, 2'b01);
      xfer(0, 1, 16'h4010, 32'h44, rd, lat);
      chk("R9 write on pin 0", cap_ce_n, 2'b10);

      // R1: mask sweep
      for (int m = 0; m < 16; m++) begin
         xfer(1, 1, A_WIN, 32'h0000_4001 | (m << 4), rd, lat);
         for (int j = 0; j < 5; j++) begin
            bit hit;
            hit = (j < 4) && m[j];
            rc0 = re_count;
            xfer(0, 0, 16'h4000 ^ 16'(1 << (8 + j)), 0, rd, lat);
            repeat (2) @(negedge clk);
            chk("R1 mask decode strobe", re_count, rc0 + (hit ? 1 : 0));
            if (!hit) chk("R1 ignored read zero", rd, 0);
         end
      end

      // R7: two-flop synchroniser delay
      @(negedge clk); nand_rb_n = 1;
      xfer(1, 0, A_STAT, 0, rd, lat); chk("R7 rb after one edge", rd[0], 0);
      xfer(1, 0, A_STAT, 0, rd, lat); chk("R7 rb after two edges", rd[0], 1);
      @(negedge clk); nand_rb_n = 0;
      xfer(1, 0, A_STAT, 0, rd, lat); chk("R7 busy after one edge", rd[0], 1);
      xfer(1, 0, A_STAT, 0, rd, lat); chk("R7 busy after two edges", rd[0], 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule